// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a stereo PCM stream into parallel samples. The stream arrives on three wires: a bit clock, a frame clock and a data line. The block works in a faster system clock domain. It synchronises the three wires, detects each rising edge of the bit clock, and takes the data and frame-clock levels at that edge. Every frame yields one left and one right sample, each 24 bits wide and in two's complement.

A 3-bit format input selects how a word sits inside its half of the frame:

| Code | Format |
|------|--------|
| 0 | LSB-justified, 16 bits |
| 1 | LSB-justified, 18 bits |
| 2 | LSB-justified, 20 bits |
| 3 | LSB-justified, 24 bits |
| 4 | 24-bit MSB-justified |
| 5 | I2S |
| 6, 7 | reserved |

LSB-justified words end on the last bit period of their half. They are found by keeping the most recent bits of the half, not by counting forward from the frame edge. A word narrower than 24 bits is sign-extended. The format takes effect only at the start of a frame.

Completed frames leave on a valid/ready output. The bit stream cannot be paused, so the output applies no back-pressure to the serial side. A sample pair stays on the output, with valid high, until it is accepted. If the next frame completes before acceptance, the new pair replaces the old one.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted and after its release, `out_valid_o` is low and both output samples are zero until the first frame completes. The internal format resets to code 5.
- R2: Data and frame-clock levels are taken at the rising edge of the bit clock. Each word is sent MSB first, in two's complement.
- R3: Codes 0 to 3 are LSB-justified with word widths of 16, 18, 20 and 24 bits. The word's LSB is the last bit before the frame-clock transition. Earlier bits in that half are ignored. Shorter words are sign-extended to 24 bits.
- R4: Code 4 is MSB-justified with a 24-bit word. The MSB is the first bit of the half, and bits after the 24th are ignored. Frame clock high marks left and low marks right, and this also holds for codes 0 to 3.
- R5: Code 5 is I2S. Frame clock low marks the left channel. The MSB comes one bit period after the frame-clock edge.
- R6: `out_valid_o` rises once per frame, in the cycle after the right word closes. It stays high with stable data until it is accepted, meaning `out_ready_i` is high while `out_valid_o` is high. A frame that completes while a pair is still pending replaces that pair.
- R7: In codes 6 and 7, both output samples are zero and a valid pair is still produced every frame. The frame clock high marks left in these codes.
- R8: The format input is taken only at frame start. A change made partway through a frame leaves that frame decoded in the format it started with.
- R9: A frame works with as few bit clocks as the word needs. That is 32, 36 and 40 bit clocks per frame for the 16, 18 and 20-bit LSB-justified codes, and 48 for the 24-bit formats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Frame (channel select) clock |
| sdata_i | input | 1 | Serial data |
| fmt_i | input | 3 | Format code (see R3 to R7) |
| out_ready_i | input | 1 | Sink accepts the pending sample pair |
| out_valid_o | output | 1 | A sample pair is pending |
| out_left_o | output | 24 | Left sample, two's complement |
| out_right_o | output | 24 | Right sample, two's complement |

## Verification
The assertions check the following on every cycle:
- The output holds valid and data stable until the pair is accepted.
- Valid rises only after a right word closes.
- The latched format changes only at a frame boundary.
- A reserved format yields zero samples.
- A narrow LSB-justified word is sign-extended.

Only the bench's scenarios can show the following:
- That each format puts the correct bits in the correct channel.
- That filler bits outside the word are ignored.
- That minimum-length frames decode.
- That a format change made partway through a frame is deferred until the next frame.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [2:0] {
    FMT_LJ16  = 3'd0,
    FMT_LJ18  = 3'd1,
    FMT_LJ20  = 3'd2,
    FMT_LJ24  = 3'd3,
    FMT_MSB24 = 3'd4,
    FMT_I2S   = 3'd5,
    FMT_RSV6  = 3'd6,
    FMT_RSV7  = 3'd7
  } fmt_e;

  // Frame-clock level that marks the left half.
  function automatic logic left_level(fmt_e f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic is_reserved(fmt_e f);
    return (f == FMT_RSV6) || (f == FMT_RSV7);
  endfunction

  // Whether the bit at index idx of a half enters the shift register.
  function automatic logic take_bit(fmt_e f, int idx);
    case (f)
      FMT_LJ16, FMT_LJ18, FMT_LJ20, FMT_LJ24: return 1'b1;
      FMT_MSB24: return idx < SAMPLE_W;
      FMT_I2S:   return (idx >= 1) && (idx <= SAMPLE_W);
      default:   return 1'b0;
    endcase
  endfunction

  // Word extraction from the bits collected in one half.
  function automatic logic [SAMPLE_W-1:0] extract(fmt_e f, logic [SAMPLE_W-1:0] sr);
    case (f)
      FMT_LJ16: return {{(SAMPLE_W-16){sr[15]}}, sr[15:0]};
      FMT_LJ18: return {{(SAMPLE_W-18){sr[17]}}, sr[17:0]};
      FMT_LJ20: return {{(SAMPLE_W-20){sr[19]}}, sr[19:0]};
      FMT_LJ24, FMT_MSB24, FMT_I2S: return sr;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_front.sv
module aud_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_i,
  input  logic lrck_i,
  input  logic sd_i,
  output logic bit_stb_o,
  output logic lr_o,
  output logic sd_o
);

  localparam int LAST = SYNC_STAGES - 1;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_st
      logic [2:0] q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= {bck_i, lrck_i, sd_i};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= g_st[g-1].q;
        end
      end
    end
  endgenerate

  logic [2:0] synced;
  logic       bck_q;
  assign synced = g_st[LAST].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q     <= 1'b0;
      bit_stb_o <= 1'b0;
      lr_o      <= 1'b0;
      sd_o      <= 1'b0;
    end else begin
      bck_q     <= synced[2];
      bit_stb_o <= synced[2] & ~bck_q;
      lr_o      <= synced[1];
      sd_o      <= synced[0];
    end
  end

endmodule

// File: rtl/aud_rx_shifter.sv
module aud_rx_shifter
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb_i,
  input  logic                lr_i,
  input  logic                sd_i,
  input  fmt_e                close_fmt_i,
  input  fmt_e                open_fmt_i,
  output logic                half_end_o,
  output logic                closed_lr_o,
  output logic [SAMPLE_W-1:0] word_o
);

  logic                primed;
  logic                lr_q;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] sr;

  assign half_end_o  = bit_stb_i & primed & (lr_i != lr_q);
  assign closed_lr_o = lr_q;
  assign word_o      = extract(close_fmt_i, sr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      lr_q   <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
    end else if (bit_stb_i) begin
      primed <= 1'b1;
      lr_q   <= lr_i;
      if (half_end_o) begin
        cnt <= CNT_W'(1);
        sr  <= take_bit(open_fmt_i, 0) ? {{(SAMPLE_W-1){1'b0}}, sd_i} : '0;
      end else begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (take_bit(close_fmt_i, int'(cnt))) sr <= {sr[SAMPLE_W-2:0], sd_i};
      end
    end
  end

  AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end_o && close_fmt_i == FMT_LJ16) |-> (word_o[SAMPLE_W-1:15] == '0 || word_o[SAMPLE_W-1:15] == '1)); // R3

endmodule

// File: rtl/aud_rx_outreg.sv
module aud_rx_outreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      left_o  <= left_i;
      right_o <= right_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(left_o) && $stable(right_o))); // R6

  AST_LOAD_PRESENTED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_o && left_o == $past(left_i) && right_o == $past(right_i))); // R6

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bck_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  input  logic                out_ready_i,
  output logic                out_valid_o,
  output logic [SAMPLE_W-1:0] out_left_o,
  output logic [SAMPLE_W-1:0] out_right_o
);

  logic bit_stb, lr_s, sd_s;

  aud_rx_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .bck_i     (bck_i),
    .lrck_i    (lrck_i),
    .sd_i      (sdata_i),
    .bit_stb_o (bit_stb),
    .lr_o      (lr_s),
    .sd_o      (sd_s)
  );

  fmt_e                frame_fmt, fmt_in, open_fmt;
  logic                half_end, closed_lr, left_close, frame_end;
  logic [SAMPLE_W-1:0] word, left_hold, left_out;

  assign fmt_in     = fmt_e'(fmt_i);
  assign left_close = half_end & (closed_lr == left_level(frame_fmt));
  assign frame_end  = half_end & ~left_close;
  assign open_fmt   = frame_end ? fmt_in : frame_fmt;
  assign left_out   = is_reserved(frame_fmt) ? '0 : left_hold;

  aud_rx_shifter #(.CNT_W(CNT_W)) i_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb_i   (bit_stb),
    .lr_i        (lr_s),
    .sd_i        (sd_s),
    .close_fmt_i (frame_fmt),
    .open_fmt_i  (open_fmt),
    .half_end_o  (half_end),
    .closed_lr_o (closed_lr),
    .word_o      (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_fmt <= FMT_I2S;
      left_hold <= '0;
    end else begin
      if (left_close) left_hold <= word;
      if (frame_end)  frame_fmt <= fmt_in;
    end
  end

  aud_rx_outreg #(.W(SAMPLE_W)) i_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (frame_end),
    .left_i  (left_out),
    .right_i (word),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .left_o  (out_left_o),
    .right_o (out_right_o)
  );

  AST_FMT_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(frame_fmt)); // R8

  AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(frame_end)); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && is_reserved(frame_fmt)) |=> (out_left_o == '0 && out_right_o == '0)); // R7

endmodule

// File: tb/test_aud_serial_rx.sv
module test_aud_serial_rx;

  localparam int CLK_P    = 10;
  localparam int BCK_HALF = 4;
  localparam int NVEC     = 10;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [7:0]  bph;
    logic [23:0] l;
    logic [23:0] r;
    logic [23:0] el;
    logic [23:0] er;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'd16, 24'h008001, 24'h001234, 24'hFF8001, 24'h001234},
    '{3'd0, 8'd32, 24'h007FFF, 24'h00C000, 24'h007FFF, 24'hFFC000},
    '{3'd1, 8'd18, 24'h020005, 24'h01FFFF, 24'hFE0005, 24'h01FFFF},
    '{3'd2, 8'd20, 24'h080000, 24'h000ABC, 24'hF80000, 24'h000ABC},
    '{3'd3, 8'd32, 24'h800000, 24'h7FFFFF, 24'h800000, 24'h7FFFFF},
    '{3'd4, 8'd24, 24'hA5A5A5, 24'h5A5A5A, 24'hA5A5A5, 24'h5A5A5A},
    '{3'd4, 8'd32, 24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA},
    '{3'd5, 8'd32, 24'h876543, 24'h0F0F0F, 24'h876543, 24'h0F0F0F},
    '{3'd6, 8'd32, 24'h111111, 24'h222222, 24'h000000, 24'h000000},
    '{3'd7, 8'd32, 24'h333333, 24'h444444, 24'h000000, 24'h000000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bck, lrck, sdata, ready;
  logic [2:0]  fmt_in;
  logic        valid;
  logic [23:0] out_l, out_r;

  logic [23:0] got_l = '0, got_r = '0;
  int          vcnt = 0;
  int          nchk = 0, nerr = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  aud_serial_rx i_aud_serial_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bck_i       (bck),
    .lrck_i      (lrck),
    .sdata_i     (sdata),
    .fmt_i       (fmt_in),
    .out_ready_i (ready),
    .out_valid_o (valid),
    .out_left_o  (out_l),
    .out_right_o (out_r)
  );

  always @(posedge clk) begin
    if (valid && ready) begin
      got_l <= out_l;
      got_r <= out_r;
      vcnt  <= vcnt + 1;
    end
  end

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic wbit(input logic [2:0] f, input int bph, input logic [23:0] w, input int i);
    int n;
    case (f)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        n = (f == 3'd0) ? 16 : (f == 3'd1) ? 18 : (f == 3'd2) ? 20 : 24;
        return (i >= bph - n) ? w[bph-1-i] : 1'b1;
      end
      3'd4:    return (i < 24) ? w[23-i] : 1'b1;
      3'd5:    return (i >= 1 && i <= 24) ? w[24-i] : 1'b1;
      default: return i[0];
    endcase
  endfunction

  task automatic send_bit(input logic lv, input logic d);
    @(negedge clk);
    lrck  = lv;
    sdata = d;
    bck   = 1'b0;
    repeat (BCK_HALF) @(negedge clk);
    bck = 1'b1;
    repeat (BCK_HALF - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] f, input int bph, input logic [23:0] l,
                            input logic [23:0] r, input int chg_at, input logic [2:0] chg_fmt);
    logic lv;
    lv = (f == 3'd5) ? 1'b0 : 1'b1;
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < bph; i++) begin
        if (h == 0 && i == chg_at) fmt_in = chg_fmt;
        send_bit((h == 0) ? lv : ~lv, wbit(f, bph, (h == 0) ? l : r, i));
      end
    end
  endtask

  function automatic string tag_of(input logic [2:0] f, input int bph);
    string t;
    t = (f <= 3'd3) ? "R3" : (f == 3'd4) ? "R4" : (f == 3'd5) ? "R5" : "R7";
    if ((f <= 3'd3 && bph < 32) || (f == 3'd4 && bph == 24)) t = {t, " R9"};
    return {t, " R2"};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog (all requirements) act=running exp=finished");
    finish_run();
  end

  initial begin
    int c0;
    rst_n  = 1'b0;
    bck    = 1'b0;
    lrck   = 1'b0;
    sdata  = 1'b0;
    ready  = 1'b1;
    fmt_in = 3'd5;
    repeat (5) @(negedge clk);
    check("R1 in reset", {47'd0, valid}, 48'd0);
    check("R1 in reset data", {out_l, out_r}, 48'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", {valid, out_l, out_r[22:0]}, 48'd0);

    // Vector table: four frames per entry, the third is checked.
    for (int v = 0; v < NVEC; v++) begin
      fmt_in = VECS[v].fmt;
      for (int k = 0; k < 4; k++)
        send_frame(VECS[v].fmt, int'(VECS[v].bph), VECS[v].l, VECS[v].r, -1, 3'd0);
      repeat (10) @(negedge clk);
      check(tag_of(VECS[v].fmt, int'(VECS[v].bph)), {got_l, got_r}, {VECS[v].el, VECS[v].er});
    end

    // R6: one valid per frame.
    fmt_in = 3'd4;
    for (int k = 0; k < 3; k++) send_frame(3'd4, 32, 24'h000111, 24'h000222, -1, 3'd0);
    c0 = vcnt;
    for (int k = 0; k < 5; k++) send_frame(3'd4, 32, 24'h000333, 24'h000444, -1, 3'd0);
    repeat (10) @(negedge clk);
    check("R6 one valid per frame", 48'(vcnt - c0), 48'd5);

    // R6: back-pressure holds and overwrites.
    ready = 1'b0;
    send_frame(3'd4, 32, 24'hAAAAAA, 24'hBBBBBB, -1, 3'd0);
    send_frame(3'd4, 32, 24'hCCCCCC, 24'hDDDDDD, -1, 3'd0);
    send_frame(3'd4, 32, 24'hEEEEEE, 24'h999999, -1, 3'd0);
    repeat (10) @(negedge clk);
    check("R6 valid held", {47'd0, valid}, 48'd1);
    check("R6 latest pair kept", {out_l, out_r}, {24'hCCCCCC, 24'hDDDDDD});
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    @(negedge clk);
    check("R6 valid dropped after accept", {47'd0, valid}, 48'd0);
    check("R6 accepted pair", {got_l, got_r}, {24'hCCCCCC, 24'hDDDDDD});
    ready = 1'b1;

    // R8: format change partway through a frame is deferred.
    fmt_in = 3'd3;
    for (int k = 0; k < 3; k++) send_frame(3'd3, 32, 24'h000001, 24'h000002, -1, 3'd0);
    send_frame(3'd3, 32, 24'h800123, 24'h00F00F, 10, 3'd6);
    send_frame(3'd3, 32, 24'h456789, 24'h654321, -1, 3'd0);
    repeat (10) @(negedge clk);
    check("R8 frame keeps its format", {got_l, got_r}, {24'h800123, 24'h00F00F});
    send_frame(3'd3, 32, 24'h456789, 24'h654321, -1, 3'd0);
    repeat (10) @(negedge clk);
    check("R7 R8 next frame reserved", {got_l, got_r}, 48'd0);

    finish_run();
  end

endmodule